// File: doc/BRIEF.md
# Dual-CPU Interrupt Posting Controller

This block collects the hardware interrupt sources of a two-processor CPU module and drives a separate set of interrupt request lines into each processor. There are five sources. A prescaled 1024 Hz interval tick goes to every CPU. Interprocessor requests are posted by a register write that names the target CPU. System-event and node-halt pulses go to every CPU. A per-CPU serial receive line raises an interrupt on each change of level. A summary of the local I/O device requests goes only to the CPU currently marked primary.

Each CPU keeps its own pending bits. Each CPU also has an enable mask that gates its request lines. A pending bit stays set until the CPU that owns it writes a 1 to that bit in its clear register.

Software reaches the block through one register port. The issuing CPU is given on `cpu_i`, and per-CPU registers are selected by it. Register reads are combinational from the address.

Top module: `irq_post_ctrl`

## Requirements
- R1: Every CPU's timer pending bit (bit 0) is set once every CLK_HZ/1024 clock cycles. The interval between two successive set events is exactly that count.
- R2: A pending bit stays set until the owning CPU writes that bit as 1 to the clear register (address 0). Writing 0 to a bit leaves it unchanged. One CPU's clear does not touch the other CPU's bits. Reading address 0 returns the issuing CPU's pending bits: timer bit 0, interprocessor bit 1, system event bit 2, node halt bit 3, serial bit 4.
- R3: A write to address 1 sets the interprocessor pending bit of every CPU k whose data bit k is 1, and a CPU may target itself. Repeated posts merge into the one bit, so a single clear removes them all.
- R4: A pulse on `sysevt_i` sets bit 2 in every CPU. A pulse on `nhalt_i` sets bit 3 in every CPU. Each of the two bits is cleared only by its own clear bit.
- R5: If a source sets a pending bit in the same cycle that a clear write hits that bit, the bit ends up set.
- R6: Address 4 reads the device request levels sampled one clock earlier, one bit per device, with several bits possibly set. `irq_io_o` of the primary CPU is high when any sampled bit is set and that CPU's enable bit 5 is 1.
- R7: The primary select (address 3, bit 0; 0 = CPU0, 1 = CPU1) resets to CPU0 and takes effect on the clock edge that writes it. The non-primary CPU's `irq_io_o` is always low.
- R8: Any change of level on a CPU's `rx_i` bit sets that CPU's serial pending bit 4. Enable bit 4 resets to 0, so `irq_serial_o` is masked by default.
- R9: Each request line equals that CPU's pending bit ANDed with its enable bit at address 2. `irq_event_o` covers bits 2 and 3. The enable register resets to 0x2F.
- R10: After reset all pending bits read 0 and all request lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_i | input | 1 | Register write strobe |
| cpu_i | input | 1 | CPU issuing the access |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i/cpu_i |
| sysevt_i | input | 1 | System event pulse |
| nhalt_i | input | 1 | Node halt pulse |
| io_req_i | input | NDEV | Local I/O device request levels |
| rx_i | input | 2 | Serial receive line per CPU |
| irq_timer_o | output | 2 | Interval timer request per CPU |
| irq_ipi_o | output | 2 | Interprocessor request per CPU |
| irq_event_o | output | 2 | System event / node halt request per CPU |
| irq_io_o | output | 2 | Local I/O request per CPU |
| irq_serial_o | output | 2 | Serial line request per CPU |

## Verification
The bench measures the interval between two timer set events to the cycle. A prescaler that is off by one would show up as a wrong spacing.

It posts several interprocessor requests to one CPU and then clears once. A design that counted requests would leave the line high after that clear.

It drives a system-event pulse in the same cycle as a clear of that bit. A clear-priority design would lose the event.

It moves the primary select and disables enables in isolation. Local I/O reaching both CPUs, a serial line that is unmasked at reset, or a clear that leaks into the other CPU would all show up as wrong line or read values.

// File: rtl/irq_post_pkg.sv
package irq_post_pkg;
    localparam int NSRC       = 5;
    localparam int SRC_TIMER  = 0;
    localparam int SRC_IPI    = 1;
    localparam int SRC_EVENT  = 2;
    localparam int SRC_HALT   = 3;
    localparam int SRC_SERIAL = 4;
    localparam int EN_IO      = 5;

    typedef enum logic [2:0] {
        A_CLEAR   = 3'd0,
        A_IPI     = 3'd1,
        A_ENABLE  = 3'd2,
        A_PRIMARY = 3'd3,
        A_IOREQ   = 3'd4
    } reg_addr_e;
endpackage

// File: rtl/irq_tick_gen.sv
module irq_tick_gen #(
    parameter int CLK_HZ  = 102_400_000,
    parameter int TICK_HZ = 1024
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic tick_o
);
    localparam int DIV = CLK_HZ / TICK_HZ;
    localparam int CW  = (DIV > 2) ? $clog2(DIV) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tick_state_t;

    tick_state_t st_d, st_q;

    assign tick_o = (st_q.cnt == CW'(DIV - 1));

    always_comb begin
        st_d = st_q;
        if (tick_o) st_d.cnt = '0;
        else        st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    // After a tick the count restarts; otherwise it advances by one (R1)
    p_tick_wrap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> (st_q.cnt == '0));
    p_tick_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tick_o |=> (st_q.cnt == $past(st_q.cnt) + 1'b1));
endmodule

// File: rtl/irq_cpu_pending.sv
module irq_cpu_pending
    import irq_post_pkg::*;
(
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [NSRC-1:0] set_i,
    input  logic [NSRC-1:0] clr_i,
    input  logic [NSRC-1:0] en_i,
    output logic [NSRC-1:0] pend_o,
    output logic [NSRC-1:0] line_o
);
    typedef struct packed {
        logic [NSRC-1:0] pend;
    } pend_state_t;

    pend_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pend = set_i | (st_q.pend & ~clr_i);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign pend_o = st_q.pend;
    assign line_o = st_q.pend & en_i;

    for (genvar i = 0; i < NSRC; i++) begin : g_chk
        // set always lands, even against a clear (R5, R3 merge)
        p_set_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            set_i[i] |=> pend_o[i]);
        // pending holds without a clear (R2)
        p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (pend_o[i] && !clr_i[i]) |=> pend_o[i]);
        // clear without set removes the bit (R2)
        p_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (clr_i[i] && !set_i[i]) |=> !pend_o[i]);
    end
endmodule

// File: rtl/irq_post_ctrl.sv
module irq_post_ctrl
    import irq_post_pkg::*;
#(
    parameter int NCPU    = 2,
    parameter int NDEV    = 4,
    parameter int DW      = 8,
    parameter int CLK_HZ  = 102_400_000,
    parameter int TICK_HZ = 1024
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            wr_i,
    input  logic            cpu_i,
    input  logic [2:0]      addr_i,
    input  logic [DW-1:0]   wdata_i,
    output logic [DW-1:0]   rdata_o,
    input  logic            sysevt_i,
    input  logic            nhalt_i,
    input  logic [NDEV-1:0] io_req_i,
    input  logic [NCPU-1:0] rx_i,
    output logic [NCPU-1:0] irq_timer_o,
    output logic [NCPU-1:0] irq_ipi_o,
    output logic [NCPU-1:0] irq_event_o,
    output logic [NCPU-1:0] irq_io_o,
    output logic [NCPU-1:0] irq_serial_o
);
    localparam logic [DW-1:0] EN_RESET = DW'(8'h2F);

    typedef struct packed {
        logic [NCPU-1:0][DW-1:0] en;
        logic                    primary;
        logic [NDEV-1:0]         io;
        logic [NCPU-1:0]         rx_prev;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;

    logic                      tick;
    logic [NCPU-1:0][NSRC-1:0] pend;
    logic [NCPU-1:0][NSRC-1:0] line;
    logic [NCPU-1:0][NSRC-1:0] set_v;
    logic [NCPU-1:0][NSRC-1:0] clr_v;
    logic [NCPU-1:0]           ipi_post;
    logic [NCPU-1:0]           rx_chg;

    irq_tick_gen #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ)) i_tick (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_o (tick)
    );

    assign ipi_post = (wr_i && addr_i == A_IPI) ? wdata_i[NCPU-1:0] : '0;
    assign rx_chg   = rx_i ^ st_q.rx_prev;

    always_comb begin
        st_d         = st_q;
        st_d.io      = io_req_i;
        st_d.rx_prev = rx_i;
        if (wr_i && addr_i == A_ENABLE)  st_d.en[cpu_i] = wdata_i;
        if (wr_i && addr_i == A_PRIMARY) st_d.primary   = wdata_i[0];
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q         <= '0;
            st_q.en      <= {NCPU{EN_RESET}};
            st_q.rx_prev <= rx_i;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        always_comb begin
            set_v[c]             = '0;
            set_v[c][SRC_TIMER]  = tick;
            set_v[c][SRC_IPI]    = ipi_post[c];
            set_v[c][SRC_EVENT]  = sysevt_i;
            set_v[c][SRC_HALT]   = nhalt_i;
            set_v[c][SRC_SERIAL] = rx_chg[c];
            clr_v[c] = (wr_i && addr_i == A_CLEAR && cpu_i == c[0])
                       ? wdata_i[NSRC-1:0] : '0;
        end

        irq_cpu_pending i_pend (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .set_i  (set_v[c]),
            .clr_i  (clr_v[c]),
            .en_i   (st_q.en[c][NSRC-1:0]),
            .pend_o (pend[c]),
            .line_o (line[c])
        );

        assign irq_timer_o[c]  = line[c][SRC_TIMER];
        assign irq_ipi_o[c]    = line[c][SRC_IPI];
        assign irq_event_o[c]  = line[c][SRC_EVENT] | line[c][SRC_HALT];
        assign irq_serial_o[c] = line[c][SRC_SERIAL];
        assign irq_io_o[c]     = (|st_q.io) && st_q.en[c][EN_IO]
                                 && (st_q.primary == c[0]);

        // only the primary CPU may see local I/O (R7)
        p_io_primary_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
            irq_io_o[c] |-> (st_q.primary == c[0]));
        // serial request needs its enable (R8)
        p_serial_masked_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !st_q.en[c][SRC_SERIAL] |-> !irq_serial_o[c]);
    end

    // at most one CPU gets local I/O (R7)
    p_io_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(irq_io_o) <= 1);

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            A_CLEAR:   rdata_o = DW'(pend[cpu_i]);
            A_ENABLE:  rdata_o = st_q.en[cpu_i];
            A_PRIMARY: rdata_o = DW'(st_q.primary);
            A_IOREQ:   rdata_o = DW'(st_q.io);
            default:   rdata_o = '0;
        endcase
    end
endmodule

// File: tb/test_irq_post_ctrl.sv
module test_irq_post_ctrl;
    localparam int TICK = 1024;
    localparam int DIV  = 4096;
    localparam int CLKH = DIV * TICK;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       wr = 0;
    logic       cpu = 0;
    logic [2:0] addr = 0;
    logic [7:0] wdata = 0;
    logic [7:0] rdata;
    logic       sysevt = 0, nhalt = 0;
    logic [3:0] io_req = 0;
    logic [1:0] rx = 0;
    logic [1:0] irq_timer, irq_ipi, irq_event, irq_io, irq_serial;

    int errors = 0, checks = 0, cyc = 0;

    typedef struct {
        int         sel;
        logic [7:0] exp;
        logic [7:0] mask;
        string      tag;
    } item_t;
    item_t sbq[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    irq_post_ctrl #(.CLK_HZ(CLKH), .TICK_HZ(TICK)) i_irq_post_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .cpu_i(cpu), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .sysevt_i(sysevt), .nhalt_i(nhalt),
        .io_req_i(io_req), .rx_i(rx), .irq_timer_o(irq_timer),
        .irq_ipi_o(irq_ipi), .irq_event_o(irq_event), .irq_io_o(irq_io),
        .irq_serial_o(irq_serial)
    );

    function automatic void check(logic [7:0] act, logic [7:0] exp, string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endfunction

    // monitor: pops expected items and compares against outputs
    always @(negedge clk) begin
        while (sbq.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it = sbq.pop_front();
            case (it.sel)
                0: act = rdata;
                1: act = {6'b0, irq_timer};
                2: act = {6'b0, irq_ipi};
                3: act = {6'b0, irq_event};
                4: act = {6'b0, irq_io};
                default: act = {6'b0, irq_serial};
            endcase
            check(act & it.mask, it.exp, it.tag);
        end
    end

    task automatic wr_reg(input logic c, input logic [2:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        wr = 1; cpu = c; addr = a; wdata = d;
        @(posedge clk); #1;
        wr = 0;
    endtask

    task automatic exp_rd(input logic c, input logic [2:0] a, input logic [7:0] m,
                          input logic [7:0] e, input string tag);
        item_t it;
        @(posedge clk); #1;
        cpu = c; addr = a;
        it.sel = 0; it.exp = e; it.mask = m; it.tag = tag;
        sbq.push_back(it);
        @(negedge clk); #1;
    endtask

    task automatic exp_irq(input int sel, input logic [1:0] e, input string tag);
        item_t it;
        @(posedge clk); #1;
        it.sel = sel; it.exp = {6'b0, e}; it.mask = 8'hFF; it.tag = tag;
        sbq.push_back(it);
        @(negedge clk); #1;
    endtask

    task automatic pulse(input logic s, input logic h);
        @(posedge clk); #1;
        sysevt = s; nhalt = h;
        @(posedge clk); #1;
        sysevt = 0; nhalt = 0;
    endtask

    initial begin
        #4_000_000;
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int t0, t1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R10 reset state, R9 enable reset, R7 primary reset
        exp_rd(0, 3'd0, 8'hFF, 8'h00, "R10 pend cpu0");
        exp_rd(1, 3'd0, 8'hFF, 8'h00, "R10 pend cpu1");
        exp_rd(1, 3'd2, 8'hFF, 8'h2F, "R9 enable reset");
        exp_rd(0, 3'd3, 8'hFF, 8'h00, "R7 primary reset");
        exp_irq(1, 2'b00, "R10 timer line");
        exp_irq(3, 2'b00, "R10 event line");

        // R1 first tick
        while (irq_timer == 2'b00) @(negedge clk);
        t0 = cyc;
        check({6'b0, irq_timer}, 8'h03, "R1 timer to all cpus");
        exp_rd(0, 3'd0, 8'h01, 8'h01, "R1 timer bit0");
        // R2 per-CPU clear, zero write no effect
        wr_reg(0, 3'd0, 8'h01);
        exp_irq(1, 2'b10, "R2 clear cpu0 only");
        wr_reg(1, 3'd0, 8'h1E);
        exp_irq(1, 2'b10, "R2 zero write no effect");
        wr_reg(1, 3'd0, 8'h01);
        exp_irq(1, 2'b00, "R2 clear cpu1");

        // R3 interprocessor posting and merge
        wr_reg(0, 3'd1, 8'h02);
        exp_irq(2, 2'b10, "R3 post to cpu1");
        wr_reg(1, 3'd1, 8'h02);
        wr_reg(1, 3'd1, 8'h02);
        exp_rd(1, 3'd0, 8'h1E, 8'h02, "R3 merged bit");
        wr_reg(1, 3'd0, 8'h02);
        exp_irq(2, 2'b00, "R3 single clear removes merged");
        wr_reg(0, 3'd1, 8'h01);
        exp_irq(2, 2'b01, "R3 self target");
        wr_reg(0, 3'd0, 8'h02);

        // R4 system event / node halt
        pulse(1, 0);
        exp_rd(0, 3'd0, 8'h1E, 8'h04, "R4 sysevt cpu0");
        exp_irq(3, 2'b11, "R4 event line both");
        wr_reg(0, 3'd0, 8'h08);
        exp_rd(0, 3'd0, 8'h1E, 8'h04, "R4 halt clear leaves event");
        wr_reg(0, 3'd0, 8'h04);
        exp_irq(3, 2'b10, "R4 event cleared cpu0");
        pulse(0, 1);
        exp_rd(0, 3'd0, 8'h1E, 8'h08, "R4 halt cpu0");
        exp_rd(1, 3'd0, 8'h1E, 8'h0C, "R4 both cpu1");
        wr_reg(0, 3'd0, 8'h08);
        wr_reg(1, 3'd0, 8'h0C);
        exp_irq(3, 2'b00, "R4 all cleared");

        // R5 set wins over same-cycle clear
        @(posedge clk); #1;
        wr = 1; cpu = 0; addr = 3'd0; wdata = 8'h04; sysevt = 1;
        @(posedge clk); #1;
        wr = 0; sysevt = 0;
        exp_rd(0, 3'd0, 8'h1E, 8'h04, "R5 set wins");
        wr_reg(0, 3'd0, 8'h04);
        wr_reg(1, 3'd0, 8'h04);
        exp_irq(3, 2'b00, "R5 cleanup");

        // R6 / R7 local I/O
        @(posedge clk); #1 io_req = 4'b0101;
        exp_rd(0, 3'd4, 8'hFF, 8'h05, "R6 io read");
        exp_irq(4, 2'b01, "R6 io to primary cpu0");
        wr_reg(0, 3'd3, 8'h01);
        exp_irq(4, 2'b10, "R7 primary moved");
        wr_reg(1, 3'd2, 8'h0F);
        exp_irq(4, 2'b00, "R6 io enable off");
        wr_reg(1, 3'd2, 8'h2F);
        @(posedge clk); #1 io_req = 4'b0000;
        exp_irq(4, 2'b00, "R6 io released");

        // R8 serial change, masked by default
        @(posedge clk); #1 rx = 2'b10;
        exp_rd(1, 3'd0, 8'h1E, 8'h10, "R8 serial pending");
        exp_irq(5, 2'b00, "R8 masked by default");
        wr_reg(1, 3'd2, 8'h3F);
        exp_irq(5, 2'b10, "R8 unmasked");
        wr_reg(1, 3'd0, 8'h10);

        // R9 enable gating
        wr_reg(0, 3'd2, 8'h2D);
        wr_reg(0, 3'd1, 8'h01);
        exp_rd(0, 3'd0, 8'h1E, 8'h02, "R9 pending while masked");
        exp_irq(2, 2'b00, "R9 line masked");
        wr_reg(0, 3'd2, 8'h2F);
        exp_irq(2, 2'b01, "R9 line enabled");
        wr_reg(0, 3'd0, 8'h02);

        // R1 period
        while (irq_timer == 2'b00) @(negedge clk);
        t1 = cyc;
        check(8'((t1 - t0) == DIV), 8'h01, "R1 period");

        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule